// File: doc/BRIEF.md
# Key Event Queue with Overflow

This block buffers key events from a keypad scanner in a small circular queue. Each event is a key code plus a press/release flag, and it is stored as one byte. Software reaches the queue through two read views. The consuming read advances the queue by one slot. The repeat read looks at any slot relative to the current start and changes nothing.

On every accepted event the block asks the control logic to raise the keypad interrupt. A push into a full queue is dropped, and the block then asks for the FIFO-overflow error to be raised. The control logic owns the status and error registers. It feeds back a single "overflow still pending" input, and while that input is high the queue refuses further events without reporting anything. A clear input, driven by configuration writes, empties the queue.

The consuming read moves the start pointer first and only then returns data. For that reason it returns zero unless at least two entries are held. The slot at the start pointer stays visible through the repeat read at index 0.

Top module: `key_event_queue`

## Requirements
- R1: After reset, the length is 0 and both read views return 0x00.
- R2: An accepted push stores a byte whose bit 7 is the press flag and whose bits 6:0 are the key code. It is written at slot (start+length) mod DEPTH.
- R3: A push with length equal to DEPTH is dropped and the length does not grow. In that cycle `error_set` bit 6 and `status_set` bit 3 are 1.
- R4: While `ovf_block` is high, a push is ignored: the length and storage are unchanged, and `status_set` and `error_set` are 0x00.
- R5: An accepted push drives `status_set` to 0x01 (bit 0, keypad event) in that cycle and grows the length by one.
- R6: A consuming read with length ≤ 1 returns 0x00 and changes neither the start pointer nor the length.
- R7: A consuming read with length ≥ 2 returns the entry at (start+1) mod DEPTH. On the next edge it advances start by one and decrements the length.
- R8: A repeat read at index i returns the entry at (start+i) mod DEPTH when i < length, and 0x00 otherwise. It changes no state.
- R9: `clr` sets start and length to 0 on the next edge and overrides any push or read in the same cycle. In that cycle `pop_data`, `status_set` and `error_set` are 0x00.
- R10: A push and a consuming read in the same cycle leave the length unchanged. Fullness is judged on the length before the read.
- R11: Start and write pointers wrap modulo DEPTH, and the length never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_vld | input | 1 | Key event offered by the scanner this cycle |
| push_code | input | 7 | Key code of the offered event |
| push_press | input | 1 | 1 = press, 0 = release |
| pop_req | input | 1 | Consuming read this cycle |
| rpt_idx | input | $clog2(DEPTH)+1 | Repeat read index relative to start |
| clr | input | 1 | Empty the queue (configuration write) |
| ovf_block | input | 1 | Overflow error still pending in control logic |
| pop_data | output | 8 | Consuming read result (combinational) |
| rpt_data | output | 8 | Repeat read result (combinational) |
| q_len | output | $clog2(DEPTH)+1 | Current number of entries |
| status_set | output | 8 | Status bits to set this cycle (bit 0 keypad, bit 3 error) |
| error_set | output | 8 | Error bits to set this cycle (bit 6 FIFO overflow) |

## Verification
The bench builds the block with its default DEPTH of 16. At that depth a fill to overflow takes only sixteen pushes, so overflow, the blocked state and several pointer wraps all fit in a short run. The 5-bit repeat index is swept past the length and past DEPTH, which brings both zero-return cases of the repeat read within reach.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  localparam int KEY_W         = 7;
  localparam int ENT_W         = KEY_W + 1;
  localparam int STAT_KEY_BIT  = 0;
  localparam int STAT_ERR_BIT  = 3;
  localparam int ERR_OVF_BIT   = 6;

  typedef logic [ENT_W-1:0] entry_t;

  // press flag in the top bit, key code below it
  function automatic entry_t pack_entry(input logic [KEY_W-1:0] code, input logic press);
    return {press, code};
  endfunction
endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [PTR_W-1:0] ra_ptr,
  output logic [ENT_W-1:0] ra_data,
  input  logic [PTR_W-1:0] rb_ptr,
  output logic [ENT_W-1:0] rb_data
);
  logic [ENT_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && (wr_ptr == PTR_W'(g)))
        slot_q[g] <= wr_data;
    end
  end

  assign ra_data = slot_q[ra_ptr];
  assign rb_data = slot_q[rb_ptr];
endmodule

// File: rtl/keyq_ctrl.sv
module keyq_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LEN_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_vld,
  input  logic             pop_req,
  input  logic             clr,
  input  logic             ovf_block,
  output logic [PTR_W-1:0] start_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [LEN_W-1:0] len,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf_evt
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);

  logic [PTR_W-1:0] start_q;
  logic [LEN_W-1:0] len_q;
  logic             push_try;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] base,
                                                input logic [PTR_W-1:0] off);
    return base + off;
  endfunction

  function automatic logic [LEN_W-1:0] next_len(input logic [LEN_W-1:0] cur,
                                                input logic inc, input logic dec);
    return cur + LEN_W'(inc) - LEN_W'(dec);
  endfunction

  assign push_try = push_vld && !clr && !ovf_block;
  assign push_ok  = push_try && (len_q != FULL_LEN);
  assign ovf_evt  = push_try && (len_q == FULL_LEN);
  assign pop_ok   = pop_req && !clr && (len_q > LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
    end else if (clr) begin
      start_q <= '0;
      len_q   <= '0;
    end else begin
      if (pop_ok) start_q <= wrap_add(start_q, PTR_W'(1));
      len_q <= next_len(len_q, push_ok, pop_ok);
    end
  end

  assign start_ptr = start_q;
  assign len       = len_q;
  assign wr_ptr    = wrap_add(start_q, len_q[PTR_W-1:0]);
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
  import keyq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LEN_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_vld,
  input  logic [KEY_W-1:0] push_code,
  input  logic             push_press,
  input  logic             pop_req,
  input  logic [LEN_W-1:0] rpt_idx,
  input  logic             clr,
  input  logic             ovf_block,
  output logic [ENT_W-1:0] pop_data,
  output logic [ENT_W-1:0] rpt_data,
  output logic [LEN_W-1:0] q_len,
  output logic [7:0]       status_set,
  output logic [7:0]       error_set
);
  logic [PTR_W-1:0] start_ptr, wr_ptr, pop_ptr, rpt_ptr;
  logic [ENT_W-1:0] pop_raw, rpt_raw;
  logic             push_ok, pop_ok, ovf_evt;

  keyq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vld  (push_vld),
    .pop_req   (pop_req),
    .clr       (clr),
    .ovf_block (ovf_block),
    .start_ptr (start_ptr),
    .wr_ptr    (wr_ptr),
    .len       (q_len),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .ovf_evt   (ovf_evt)
  );

  // consuming read looks one slot past start (pointer moves before data)
  assign pop_ptr = start_ptr + PTR_W'(1);
  assign rpt_ptr = start_ptr + rpt_idx[PTR_W-1:0];

  keyq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_ptr  (wr_ptr),
    .wr_data (pack_entry(push_code, push_press)),
    .ra_ptr  (pop_ptr),
    .ra_data (pop_raw),
    .rb_ptr  (rpt_ptr),
    .rb_data (rpt_raw)
  );

  assign pop_data = pop_ok ? pop_raw : '0;
  assign rpt_data = (rpt_idx < q_len) ? rpt_raw : '0;

  always_comb begin
    status_set = '0;
    error_set  = '0;
    status_set[STAT_KEY_BIT] = push_ok;
    status_set[STAT_ERR_BIT] = ovf_evt;
    error_set[ERR_OVF_BIT]   = ovf_evt;
  end
endmodule

// File: rtl/keyq_checker.sv
module keyq_checker #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pop_req,
  input logic             clr,
  input logic             ovf_block,
  input logic [LEN_W-1:0] q_len,
  input logic [7:0]       pop_data,
  input logic [7:0]       status_set,
  input logic [7:0]       error_set,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             ovf_evt
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);

  p_len_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_len <= FULL_LEN);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_len == '0));

  p_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (q_len == $past(q_len) + LEN_W'(1)));

  p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pop_req) |=> (q_len == FULL_LEN));

  p_err_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    error_set[6] |-> status_set[3]);

  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_block |-> (status_set == 8'h00 && error_set == 8'h00));

  p_short_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && q_len <= LEN_W'(1)) |-> (pop_data == 8'h00));

  p_simul_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(q_len));
endmodule

bind key_event_queue keyq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pop_req    (pop_req),
  .clr        (clr),
  .ovf_block  (ovf_block),
  .q_len      (q_len),
  .pop_data   (pop_data),
  .status_set (status_set),
  .error_set  (error_set),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .ovf_evt    (ovf_evt)
);

// File: tb/key_event_queue_bench.sv
`timescale 1ns/1ps
module key_event_queue_bench;
  localparam int DEPTH = 16;
  localparam int LEN_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_vld = 0, push_press = 0, pop_req = 0, clr = 0, ovf_block = 0;
  logic [6:0] push_code = '0;
  logic [LEN_W-1:0] rpt_idx = '0;
  logic [7:0] pop_data, rpt_data, status_set, error_set;
  logic [LEN_W-1:0] q_len;

  always #10 clk = ~clk;

  key_event_queue #(.DEPTH(DEPTH)) u_key_event_queue (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_code(push_code),
    .push_press(push_press), .pop_req(pop_req), .rpt_idx(rpt_idx), .clr(clr),
    .ovf_block(ovf_block), .pop_data(pop_data), .rpt_data(rpt_data),
    .q_len(q_len), .status_set(status_set), .error_set(error_set)
  );

  // behavioural reference
  int m_mem [DEPTH];
  int m_start = 0, m_len = 0;
  int n_checks = 0, n_fail = 0;
  int idx_sweep = 0;
  string tag = "R1";
  bit done = 0;

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit p, input int code, input bit pr, input bit pop,
                      input bit c, input bit blk);
    int idx, e_pop, e_rpt, e_stat, e_err;
    bit pok, ook, ovf;
    @(negedge clk);
    idx = idx_sweep % 20;
    idx_sweep++;
    push_vld = p; push_code = 7'(code); push_press = pr; pop_req = pop;
    clr = c; ovf_block = blk; rpt_idx = LEN_W'(idx);
    #1;
    pok = p && !c && !blk && (m_len < DEPTH);
    ovf = p && !c && !blk && (m_len == DEPTH);
    ook = pop && !c && (m_len > 1);
    e_pop  = ook ? m_mem[(m_start + 1) % DEPTH] : 0;
    e_rpt  = (idx < m_len) ? m_mem[(m_start + idx) % DEPTH] : 0;
    e_stat = (pok ? 1 : 0) + (ovf ? 8 : 0);
    e_err  = ovf ? 64 : 0;
    check("q_len", int'(q_len), m_len);
    check("pop_data", int'(pop_data), e_pop);
    check("rpt_data", int'(rpt_data), e_rpt);
    check("status_set", int'(status_set), e_stat);
    check("error_set", int'(error_set), e_err);
    @(posedge clk);
    if (c) begin
      m_start = 0; m_len = 0;
    end else begin
      if (pok) m_mem[(m_start + m_len) % DEPTH] = (pr ? 128 : 0) + (code & 127);
      if (ook) m_start = (m_start + 1) % DEPTH;
      m_len = m_len + (pok ? 1 : 0) - (ook ? 1 : 0);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    tag = "R1";
    check("q_len", int'(q_len), 0);
    check("rpt_data", int'(rpt_data), 0);
    check("pop_data", int'(pop_data), 0);
    rst_n = 1'b1;
    // R6 short consuming reads
    tag = "R6";
    step(0, 0, 0, 1, 0, 0);
    step(1, 7'h3c, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    // R2 and R5 pushes with mixed codes
    tag = "R2_R5";
    for (int i = 0; i < 6; i++) step(1, 7'h11 * i + 3, i[0], 0, 0, 0);
    // R7 and R8 reads
    tag = "R7_R8";
    for (int i = 0; i < 8; i++) step(0, 0, 0, i < 5, 0, 0);
    // R10 simultaneous push and read
    tag = "R10";
    for (int i = 0; i < 6; i++) step(1, 7'h40 + i, 1, 1, 0, 0);
    // R11 wrap by many push/read cycles
    tag = "R11";
    for (int i = 0; i < 40; i++) step(i % 3 != 2, 7'h05 + i, i[1], i % 2 == 0, 0, 0);
    // R3 fill to overflow
    tag = "R3";
    for (int i = 0; i < DEPTH + 2; i++) step(1, 7'h60 + i, 0, 0, 0, 0);
    step(1, 7'h7f, 1, 1, 0, 0);
    step(1, 7'h7e, 1, 0, 0, 0);
    // R4 blocked while overflow pending
    tag = "R4";
    step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 7'h22 + i, 1, 0, 0, 1);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 1);
    // R9 clear overrides push and read
    tag = "R9";
    step(1, 7'h01, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 7'h30 + i, 0, 0, 0, 0);
    step(1, 7'h0a, 1, 0, 1, 0);
    for (int i = 0; i < 20; i++) step(i < 3, 7'h50 + i, 1, i > 5, 0, 0);
    // R8 index sweep past length on a full queue
    tag = "R8";
    for (int i = 0; i < DEPTH; i++) step(1, i, 1, 0, 0, 0);
    for (int i = 0; i < 24; i++) step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule